// File: doc/BRIEF.md
# Pseudo-SRAM Access Controller

This block sits between a synchronous host and a 1M x 16 pseudo-static RAM that has an asynchronous SRAM-style pin interface. The host issues one request at a time with an address, a write flag, write data and a two-bit byte enable. The controller turns each request into a sequence of pin-level phases whose lengths are whole clock cycles. Every phase length is derived from a nanosecond figure and the clock period by rounding up, with a floor of one cycle.

After reset the controller keeps the chip deselected through the memory's power-up wait. During that wait it holds `ready` low. Reads keep output enable and the byte strobes low for the full access time and capture the data in the final cycle. Writes drive the data bus only while write enable is low, and follow with a recovery phase so that the write cycle time is met. When a write follows a read, the controller holds off driving the bus until the memory has released it.

Back-to-back accesses keep the chip selected across a single idle cycle. A run counter forces one deselected cycle before the continuous-select limit can be reached.

Top module: `psram_ctrl`

## Requirements
- R1: After reset `mem_cs_n` stays high and `ready` stays low for at least PU_CYC cycles (50,000 at a 4 ns clock, 200 us).
- R2: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_addr` stable for RD_CYC cycles (18 by default). The bus is captured in the last of those cycles. `rdata_valid` is a one-cycle pulse in the cycle after the last read cycle, which is RD_CYC+1 cycles after the accepting edge.
- R3: `req_be[1]` low-asserts `mem_ub_n` for data bits 15:8 and `req_be[0]` low-asserts `mem_lb_n` for bits 7:0. A lane that is not enabled reads back as zero in `rdata`.
- R4: `mem_we_n` is low only while `mem_cs_n` is low and `mem_oe_n` is high. It stays low for WP_CYC cycles (13 by default). `mem_dq_oe` is high exactly while `mem_we_n` is low, and `mem_dq_out` holds constant during that time.
- R5: After `mem_we_n` rises, a recovery phase of REC_CYC cycles (5 by default) passes before `ready` returns.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: A write that directly follows a read waits TA_CYC cycles (5 by default) after output enable rises before lowering `mem_we_n`. A write that follows a write, or that is the first access, lowers it in the first cycle after acceptance.
- R8: `mem_cs_n` never stays low for more than RUN_MAX consecutive cycles (2,500 by default, 10 us). A request presented in the first idle cycle after an access keeps the chip selected.
- R9: A request is accepted only on a cycle where `ready` is high. `ready` falls in the next cycle and stays low until the access completes.
- R10: A write with `req_be` equal to 00 leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper lane |
| ready | output | 1 | Controller can accept a request |
| rdata | output | 16 | Read data, disabled lanes zero |
| rdata_valid | output | 1 | One-cycle read completion pulse |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | 20 | Memory address |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_out | output | 16 | Data bus output value |
| mem_dq_in | input | 16 | Data bus input value |

## Verification
The assertions assume the host changes `req` and its fields only outside the clock edge. They also assume the host presents a request only when it intends it to be taken under the `ready` handshake. The bench meets this by raising `req` at a falling edge where `ready` is high and dropping it right after the next rising edge. The assertions assume nothing about `mem_dq_in`. The bench's memory model drives it combinationally from the chip's strobes and fills disabled lanes with a non-zero filler byte, so that lane masking becomes visible at the ports.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int unsigned PS_AW   = 20;
    localparam int unsigned PS_DW   = 16;
    localparam int unsigned PS_BEW  = 2;
    localparam int unsigned PS_LANE = PS_DW / PS_BEW;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_REST,
        ST_READ,
        ST_WTURN,
        ST_WPULSE,
        ST_WREC
    } ps_state_e;

    typedef struct packed {
        logic                 we;
        logic [PS_AW-1:0]     addr;
        logic [PS_DW-1:0]     wdata;
        logic [PS_BEW-1:0]    be;
    } ps_req_t;

    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [PS_DW-1:0] lane_mask(logic [PS_BEW-1:0] be);
        logic [PS_DW-1:0] m;
        for (int i = 0; i < PS_DW; i++) m[i] = be[i / PS_LANE];
        return m;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
    parameter int unsigned W       = 16,
    parameter int unsigned RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= W'(RST_VAL);
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/psram_sel_limiter.sv
module psram_sel_limiter #(
    parameter int unsigned RUN_MAX = 2500,
    parameter int unsigned ACC_MAX = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic near
);
    localparam int unsigned CW     = $clog2(RUN_MAX + 1);
    localparam int unsigned THRESH = RUN_MAX - ACC_MAX - 2;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || cs_n) run_cnt <= '0;
        else             run_cnt <= run_cnt + 1'b1;
    end

    assign near = (run_cnt >= CW'(THRESH));

    assert_sel_cap_R8: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (run_cnt < CW'(RUN_MAX)));
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned CLK_NS    = 4,
    parameter int unsigned PU_NS     = 200000,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_OE_NS   = 25,
    parameter int unsigned T_WP_NS   = 50,
    parameter int unsigned T_DW_NS   = 20,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_HZ_NS   = 20,
    parameter int unsigned T_RUN_NS  = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [PS_AW-1:0]  req_addr,
    input  logic [PS_DW-1:0]  req_wdata,
    input  logic [PS_BEW-1:0] req_be,
    output logic              ready,
    output logic [PS_DW-1:0]  rdata,
    output logic              rdata_valid,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [PS_AW-1:0]  mem_addr,
    output logic              mem_dq_oe,
    output logic [PS_DW-1:0]  mem_dq_out,
    input  logic [PS_DW-1:0]  mem_dq_in
);
    localparam int unsigned PU_CYC  = ns2cyc(PU_NS, CLK_NS);
    localparam int unsigned RD_CYC  = umax(ns2cyc(T_RC_NS, CLK_NS),
                                      umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
    localparam int unsigned WP_CYC  = umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS));
    localparam int unsigned WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned TA_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned RUN_MAX = T_RUN_NS / CLK_NS;
    localparam int unsigned ACC_MAX = umax(RD_CYC, TA_CYC + WP_CYC + REC_CYC);
    localparam int unsigned TW      = $clog2(umax(PU_CYC, ACC_MAX) + 1);

    ps_state_e         state;
    ps_req_t           cur;
    logic              last_rd;
    logic              keep_sel;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_zero;
    logic              near;
    logic              in_access;
    logic              accept;
    logic [PS_BEW-1:0] strobe_n;

    psram_phase_timer #(.W(TW), .RST_VAL(PU_CYC - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    psram_sel_limiter #(.RUN_MAX(RUN_MAX), .ACC_MAX(ACC_MAX)) u_limit (
        .clk  (clk),
        .rst  (rst),
        .cs_n (mem_cs_n),
        .near (near)
    );

    assign in_access = (state == ST_READ) || (state == ST_WTURN) ||
                       (state == ST_WPULSE) || (state == ST_WREC);
    assign ready  = (state == ST_IDLE) && !near;
    assign accept = ready && req;

    // phase timer loading on every transition into a timed phase
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (accept) begin
                tmr_load = 1'b1;
                if (!req_we)      tmr_val = TW'(RD_CYC - 1);
                else if (last_rd) tmr_val = TW'(TA_CYC - 1);
                else              tmr_val = TW'(WP_CYC - 1);
            end
            ST_WTURN:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = TW'(WP_CYC - 1);  end
            ST_WPULSE: if (tmr_zero) begin tmr_load = 1'b1; tmr_val = TW'(REC_CYC - 1); end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_PWRUP;
            cur         <= '0;
            last_rd     <= 1'b0;
            keep_sel    <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= 1'b0;
            case (state)
                ST_PWRUP: if (tmr_zero) state <= ST_IDLE;
                ST_IDLE: begin
                    keep_sel <= 1'b0;
                    if (near) begin
                        state <= ST_REST;
                    end else if (req) begin
                        cur   <= '{we: req_we, addr: req_addr, wdata: req_wdata, be: req_be};
                        state <= !req_we ? ST_READ : (last_rd ? ST_WTURN : ST_WPULSE);
                    end
                end
                ST_REST: state <= ST_IDLE;
                ST_READ: if (tmr_zero) begin
                    rdata       <= mem_dq_in & lane_mask(cur.be);
                    rdata_valid <= 1'b1;
                    last_rd     <= 1'b1;
                    keep_sel    <= 1'b1;
                    state       <= ST_IDLE;
                end
                ST_WTURN:  if (tmr_zero) state <= ST_WPULSE;
                ST_WPULSE: if (tmr_zero) begin
                    last_rd <= 1'b0;
                    state   <= ST_WREC;
                end
                ST_WREC: if (tmr_zero) begin
                    keep_sel <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < PS_BEW; g++) begin : g_strobe
            assign strobe_n[g] = !(in_access && cur.be[g]);
        end
    endgenerate

    assign mem_cs_n   = !(in_access || ((state == ST_IDLE) && keep_sel));
    assign mem_oe_n   = (state != ST_READ);
    assign mem_we_n   = (state != ST_WPULSE);
    assign mem_ub_n   = strobe_n[1];
    assign mem_lb_n   = strobe_n[0];
    assign mem_addr   = cur.addr;
    assign mem_dq_oe  = (state == ST_WPULSE);
    assign mem_dq_out = cur.wdata;

    assert_we_in_sel_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

    assert_wdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

    assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);
endmodule

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;
    localparam int PU_CYC  = 50000;
    localparam int RD_CYC  = 18;
    localparam int WP_CYC  = 13;
    localparam int REC_CYC = 5;
    localparam int TA_CYC  = 5;
    localparam int RUN_MAX = 2500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ready, rdata_valid;
    logic [15:0] rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    psram_ctrl u_dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .rdata(rdata),
        .rdata_valid(rdata_valid), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in)
    );

    // behavioural memory model, 256 words
    logic [15:0] mem [256];
    logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
    logic [15:0] p_dq = '0;
    logic [15:0] w_data = '0;
    logic [7:0]  w_addr = '0;
    logic        w_ub = 1'b0, w_lb = 1'b0;
    int          since_oe = 1000;
    int          cs_run = 0, cs_run_max = 0;
    int          ta_bad = 0, drive_bad = 0, hold_bad = 0;

    always_comb begin
        mem_dq_in[15:8] = (!mem_cs_n && !mem_oe_n && !mem_ub_n) ? mem[mem_addr[7:0]][15:8] : 8'hEE;
        mem_dq_in[7:0]  = (!mem_cs_n && !mem_oe_n && !mem_lb_n) ? mem[mem_addr[7:0]][7:0]  : 8'hEE;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && !mem_we_n) begin
                w_data = mem_dq_out; w_addr = mem_addr[7:0];
                w_ub = !mem_ub_n; w_lb = !mem_lb_n;
            end
            if (!p_we_n && mem_we_n) begin
                if (w_ub) mem[w_addr][15:8] = w_data[15:8];
                if (w_lb) mem[w_addr][7:0]  = w_data[7:0];
            end
            if (!mem_we_n && !p_we_n && mem_dq_out != p_dq) hold_bad++;
            if (mem_dq_oe != !mem_we_n) hold_bad++;
            if (mem_dq_oe && !mem_oe_n) drive_bad++;
            if (mem_oe_n) since_oe = p_oe_n ? since_oe + 1 : 1;
            else          since_oe = 0;
            if (mem_dq_oe && !p_dq_oe && since_oe < TA_CYC) ta_bad++;
            cs_run = mem_cs_n ? 0 : cs_run + 1;
            if (cs_run > cs_run_max) cs_run_max = cs_run;
            p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe; p_dq = mem_dq_out;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic we, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        #1 req = 1'b0;
    endtask

    task automatic do_read(input logic [19:0] a, input logic [1:0] be, input logic [15:0] exp, input bit chk_lat);
        int n;
        issue(1'b0, a, 16'h0, be);
        n = 0;
        do begin @(negedge clk); n++; if (n == 1) check("R9 ready low after accept", ready, 0); end
        while (!rdata_valid && n < 200);
        check("R2/R3 read data", rdata, exp);
        if (chk_lat) check("R2 read latency", n, RD_CYC + 1);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be, input int exp_start);
        int n, lw, rc;
        issue(1'b1, a, d, be);
        n = 0;
        do begin @(negedge clk); n++; end while (mem_we_n && n < 200);
        check("R7 write start", n, exp_start);
        check("R3 upper strobe", mem_ub_n, !be[1]);
        check("R3 lower strobe", mem_lb_n, !be[0]);
        lw = 0;
        while (!mem_we_n && lw < 200) begin lw++; @(negedge clk); end
        check("R4 we pulse", lw, WP_CYC);
        rc = 0;
        while (!ready && rc < 200) begin rc++; @(negedge clk); end
        check("R5 recovery", rc, REC_CYC);
    endtask

    task automatic test_powerup;
        int n;
        bit cs_ok;
        n = 0; cs_ok = 1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset ready", ready, 0);
        while (!ready && n < PU_CYC + 100) begin
            if (!mem_cs_n) cs_ok = 0;
            @(negedge clk); n++;
        end
        check("R1 cs held high", cs_ok, 1);
        check("R1 wait long enough", (n >= PU_CYC) && (n <= PU_CYC + 2), 1);
    endtask

    task automatic test_bytes;
        do_write(20'h10, 16'hA5C3, 2'b11, 1);
        check("R4 word written", mem[8'h10], 16'hA5C3);
        do_read(20'h10, 2'b11, 16'hA5C3, 1);
        do_write(20'h10, 16'h7700, 2'b10, 1 + TA_CYC);
        check("R3 upper lane write", mem[8'h10], 16'h77C3);
        do_write(20'h10, 16'h0011, 2'b01, 1);
        check("R3 lower lane write", mem[8'h10], 16'h7711);
        do_read(20'h10, 2'b01, 16'h0011, 1);
        do_read(20'h10, 2'b10, 16'h7700, 1);
    endtask

    task automatic test_no_lane;
        do_write(20'h10, 16'hFFFF, 2'b00, 1 + TA_CYC);
        check("R10 memory unchanged", mem[8'h10], 16'h7711);
        do_read(20'h10, 2'b11, 16'h7711, 1);
        do_write(20'h3C, 16'h1234, 2'b11, 1 + TA_CYC);
        do_read(20'h3C, 2'b11, 16'h1234, 1);
    endtask

    task automatic test_chain;
        for (int i = 0; i < 140; i++) do_read(20'h3C, 2'b11, 16'h1234, 0);
        check("R8 select run within cap", cs_run_max <= RUN_MAX, 1);
        check("R8 selection chained", cs_run_max > 2000, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (4) @(negedge clk);
        test_powerup();
        test_bytes();
        test_no_lane();
        test_chain();
        check("R6 no drive while output enabled", drive_bad, 0);
        check("R7 turnaround gap", ta_bad, 0);
        check("R4 data hold and drive window", hold_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule